// File: doc/BRIEF.md
# Bounce-Free Operator Switch Flag

This block turns the two contacts of a single-pole double-throw operator switch into a single event flag. It raises the flag exactly once for each press, however much either contact chatters. It does this without a timer. The two contacts act as a set/reset pair, so the pressed/released state can only change when the opposite contact makes. The host clears the flag as a side effect of reading the clear offset, which returns all ones. When the interrupt enable is set, the flag drives an active-high interrupt request.

Two controllers work in series. The contact controller has the states `CT_RELEASED` and `CT_PRESSED`. The transition *make* (`CT_RELEASED` to `CT_PRESSED`) fires when the make contact is closed and the break contact is open. The transition *break* (`CT_PRESSED` to `CT_RELEASED`) fires when the break contact is closed and the make contact is open. Every other contact combination holds the state. The flag controller has the states `FL_IDLE` and `FL_PENDING`. The transition *arm* (`FL_IDLE` to `FL_PENDING`) fires on each *make* transition. The transition *ack* (`FL_PENDING` to `FL_IDLE`) fires on a clearing read, except in a cycle where *arm* also fires.

Top module: `swflag_top`

## Requirements
- R1: Both contact inputs are active low (0 = closed) and each passes through a two-flop synchroniser. After the make contact closes with the break contact open, `flag` is still 0 after the second rising edge and is 1 after the third.
- R2: Once the contact controller is in `CT_PRESSED`, any bouncing of the make contact (break contact staying open) does not set `flag` again.
- R3: The controller returns to `CT_RELEASED` only when the break contact is closed and the make contact is open. Bouncing of the break contact alone never sets `flag`.
- R4: When both contacts are open, or both are closed, the contact controller holds its state. A press seen while both are closed sets `flag` only once the break contact opens.
- R5: A cycle with `host_rd`=1 and `host_addr`=3 clears `flag` at that rising edge. While `host_addr`=3, `rd_data` is 8'hFF.
- R6: Reads at offsets 0, 1 and 2 leave `flag` unchanged.
- R7: If a clearing read and a *make* transition fall in the same clock, `flag` stays 1.
- R8: `irq` equals `flag` AND `irq_en` at all times and is active high.
- R9: At offset 0, `rd_data` is the status byte: `flag` in bit 7 and zeros elsewhere. Offsets 1 and 2 return 8'h00.
- R10: After reset, `flag` and `irq` are 0 and the controller is in `CT_RELEASED`. A press held through reset sets `flag` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| make_n | input | 1 | Normally-open contact, 0 = closed |
| break_n | input | 1 | Normally-closed contact, 0 = closed |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | 2 | Host read offset |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Read data for the selected offset |
| flag | output | 1 | Latched press flag |
| irq | output | 1 | Active-high interrupt request |

## Verification
Contact changes reach `flag` three rising edges after they are driven: two synchroniser flops and then the flag register. The bench therefore drives on a falling edge and samples both after the second edge and after the third. A clearing read takes effect at the single rising edge on which it is sampled. `rd_data` and `irq` are combinational, so the bench checks them in the same half-cycle in which it drives them. Bounce sweeps toggle one contact 1 to 6 times, one cycle per toggle. After each sweep the bench waits out the three-edge latency before it compares `flag`.

// File: rtl/swflag_pkg.sv
package swflag_pkg;
    typedef enum logic {CT_RELEASED = 1'b0, CT_PRESSED = 1'b1} contact_t;
    typedef enum logic {FL_IDLE = 1'b0, FL_PENDING = 1'b1} flag_t;
endpackage

// File: rtl/swflag_sync.sv
module swflag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic closed
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_n};
            end
        end
    endgenerate

    // Contacts are active low: a low level at the last stage means closed.
    assign closed = ~chain[STAGES-1];
endmodule

// File: rtl/swflag_contact.sv
module swflag_contact
    import swflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mk_closed,
    input  logic brk_closed,
    output logic press_evt,
    output logic pressed
);
    contact_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CT_RELEASED;
        else        state <= nxt;
    end

    // Set/reset pair: only the opposite contact making moves the state.
    always_comb begin
        nxt = state;
        unique case (state)
            CT_RELEASED: if (mk_closed && !brk_closed) nxt = CT_PRESSED;
            CT_PRESSED:  if (brk_closed && !mk_closed) nxt = CT_RELEASED;
            default:     nxt = CT_RELEASED;
        endcase
    end

    always_comb begin
        press_evt = (state == CT_RELEASED) && (nxt == CT_PRESSED);
        pressed   = (state == CT_PRESSED);
    end

    // R4: contacts agreeing (both open or both closed) never move the state
    p_hold_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mk_closed == brk_closed) |=> $stable(state));
    // R2: a press event is followed by a cycle with no second event
    p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        press_evt |=> !press_evt);
    // R3: release only through the break contact
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pressed && !brk_closed) |=> pressed);
endmodule

// File: rtl/swflag_flag.sv
module swflag_flag
    import swflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_evt,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    flag_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FL_IDLE:    if (press_evt) nxt = FL_PENDING;
            FL_PENDING: if (clr_req && !press_evt) nxt = FL_IDLE;
            default:    nxt = FL_IDLE;
        endcase
    end

    always_comb begin
        flag = (state == FL_PENDING);
        irq  = flag & irq_en;
    end

    // R7: a new press beats a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        press_evt |=> flag);
    // R5: a clear with no press drops the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !press_evt) |=> !flag);
    // R2: the flag only rises on a press event
    p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !press_evt |=> !$rose(flag));
    // R6: without a clear the flag never falls
    p_no_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> !$fell(flag));
endmodule

// File: rtl/swflag_top.sv
module swflag_top #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int CLR_OFFSET  = 3,
    parameter int STS_OFFSET  = 0,
    parameter int FLAG_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              make_n,
    input  logic              break_n,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFFSET);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);

    logic mk_closed, brk_closed, press_evt, pressed, clr_req;

    swflag_sync #(.STAGES(SYNC_STAGES)) u_sync_mk (
        .clk(clk), .rst_n(rst_n), .d_n(make_n), .closed(mk_closed));
    swflag_sync #(.STAGES(SYNC_STAGES)) u_sync_brk (
        .clk(clk), .rst_n(rst_n), .d_n(break_n), .closed(brk_closed));

    swflag_contact u_contact (
        .clk(clk), .rst_n(rst_n), .mk_closed(mk_closed), .brk_closed(brk_closed),
        .press_evt(press_evt), .pressed(pressed));

    assign clr_req = host_rd && (host_addr == CLR_A);

    swflag_flag u_flag (
        .clk(clk), .rst_n(rst_n), .press_evt(press_evt), .clr_req(clr_req),
        .irq_en(irq_en), .flag(flag), .irq(irq));

    always_comb begin
        rd_data = '0;
        if (host_addr == CLR_A)      rd_data = '1;
        else if (host_addr == STS_A) rd_data[FLAG_BIT] = flag;
    end

    // R10: the press state never runs ahead of the flag set after reset
    p_press_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pressed) |-> (flag || $past(clr_req)));
endmodule

// File: tb/test_swflag_top.sv
module test_swflag_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       make_n = 1'b1, break_n = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       flag, irq;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swflag_top i_swflag_top (
        .clk(clk), .rst_n(rst_n), .make_n(make_n), .break_n(break_n),
        .host_rd(host_rd), .host_addr(host_addr), .irq_en(irq_en),
        .rd_data(rd_data), .flag(flag), .irq(irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clearing read: one cycle at offset 3
    task automatic clear_read();
        host_addr = 2'd3; host_rd = 1'b1;
        #1 chk(rd_data == 8'hFF, "R5 rd_data", rd_data, 8'hFF);
        tick(1);
        host_rd = 1'b0; host_addr = 2'd0;
        chk(flag == 1'b0, "R5 clear", flag, 0);
    endtask

    task automatic press_clean();
        break_n = 1'b1; make_n = 1'b0; tick(4);
    endtask

    task automatic release_clean();
        make_n = 1'b1; break_n = 1'b0; tick(4);
    endtask

    initial begin
        tick(2);
        chk(flag == 1'b0, "R10 reset flag", flag, 0);
        chk(irq == 1'b0, "R10 reset irq", irq, 0);
        rst_n = 1'b1;
        tick(4);
        chk(flag == 1'b0, "R10 idle released", flag, 0);

        // R1: latency of a clean press
        break_n = 1'b1; make_n = 1'b0;
        tick(2);
        chk(flag == 1'b0, "R1 not before 3rd edge", flag, 0);
        tick(1);
        chk(flag == 1'b1, "R1 set at 3rd edge", flag, 1);
        host_addr = 2'd0; #1
        chk(rd_data == 8'h80, "R9 status bit7", rd_data, 8'h80);
        tick(1);

        // R8: irq gating sweep
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 2; e++) begin
                irq_en = e[0]; #1
                chk(irq == (flag & e[0]), "R8 irq gate", irq, flag & e[0]);
                tick(1);
            end
            if (f == 0) clear_read();
        end
        irq_en = 1'b0;
        host_addr = 2'd0; #1
        chk(rd_data == 8'h00, "R9 status clear", rd_data, 0);
        for (int a = 1; a < 3; a++) begin
            host_addr = a[1:0]; #1
            chk(rd_data == 8'h00, "R9 other offset", rd_data, 0);
        end
        tick(1);

        // R6: reads at offsets 0..2 do not clear
        release_clean();
        press_clean();
        for (int a = 0; a < 3; a++) begin
            host_addr = a[1:0]; host_rd = 1'b1; tick(1);
            host_rd = 1'b0;
            chk(flag == 1'b1, "R6 non-clearing read", flag, 1);
        end
        clear_read();

        // R2 and R3: bounce sweeps
        for (int nb = 1; nb <= 6; nb++) begin
            release_clean();
            clear_read();
            break_n = 1'b1;
            for (int k = 0; k < nb; k++) begin
                make_n = 1'b0; tick(1); make_n = 1'b1; tick(1);
            end
            make_n = 1'b0; tick(4);
            chk(flag == 1'b1, "R2 press with bounce", flag, 1);
            clear_read();
            for (int k = 0; k < nb; k++) begin
                make_n = 1'b1; tick(1); make_n = 1'b0; tick(1);
            end
            tick(4);
            chk(flag == 1'b0, "R2 no second set", flag, 0);
            // break contact bounce with make open: releases, no set
            make_n = 1'b1;
            for (int k = 0; k < nb; k++) begin
                break_n = 1'b0; tick(1); break_n = 1'b1; tick(1);
            end
            tick(4);
            chk(flag == 1'b0, "R3 break bounce", flag, 0);
            make_n = 1'b0; tick(4);
            chk(flag == 1'b1, "R3 rearmed by break", flag, 1);
            clear_read();
        end

        // R4: both-closed holds released, neither holds pressed
        release_clean();
        make_n = 1'b0; break_n = 1'b0; tick(5);
        chk(flag == 1'b0, "R4 both closed holds", flag, 0);
        break_n = 1'b1; tick(4);
        chk(flag == 1'b1, "R4 press after both", flag, 1);
        clear_read();
        make_n = 1'b1; break_n = 1'b1; tick(5);
        make_n = 1'b0; tick(5);
        chk(flag == 1'b0, "R4 neither holds pressed", flag, 0);

        // R7: set beats clear in same cycle
        release_clean();
        press_clean();
        release_clean();
        chk(flag == 1'b1, "R7 precondition", flag, 1);
        break_n = 1'b1; make_n = 1'b0;
        tick(2);
        host_addr = 2'd3; host_rd = 1'b1;
        tick(1);
        host_rd = 1'b0; host_addr = 2'd0;
        chk(flag == 1'b1, "R7 set wins", flag, 1);
        clear_read();

        // R10: press held through reset sets flag once
        rst_n = 1'b0; tick(2);
        chk(flag == 1'b0, "R10 reset clears", flag, 0);
        rst_n = 1'b1; tick(4);
        chk(flag == 1'b1, "R10 held press", flag, 1);
        clear_read();
        tick(4);
        chk(flag == 1'b0, "R10 only once", flag, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++; checks++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule